// File: doc/BRIEF.md
# Buffered Timer Capture/Compare Channel

A 16-bit timer channel with one general register (GR) that a second, buffer register (BR) stands behind. Hardware events move values between the counter, GR and BR, and which event does so depends on the channel mode. In compare mode, a match between the counter and GR reloads GR from BR. In capture mode, a pin edge stores the counter in GR and pushes the old GR into BR, so two successive capture values are kept. In triangle PWM mode, the counter ramps up to a period value and back down to zero. BR reaches GR only at those two turning points, so duty-cycle updates never land in the middle of a slope.

Software writes the period, GR and BR through a simple register port. A BR write waits for the next hardware transfer before it has any effect, while a GR write lands at once. A sticky flag records every match, capture or turn. A parameter removes the buffer path, which leaves GR as a plain register.

The counter direction is kept in a two-state machine with the states DIR_UP and DIR_DOWN. It has these transitions:
- Peak turn: DIR_UP to DIR_DOWN, on a tick when the count equals the period.
- Floor turn: DIR_DOWN to DIR_UP, on a tick when the count is zero.
- Mode exit: any state to DIR_UP, whenever the mode is not triangle PWM.

Top module: `buf_timer_chan`

## Requirements
- R1: After reset, GR, BR, the period and the counter are 0, and both `evt_flag` and `pwm_out` are 0.
- R2: The counter changes only on cycles where `tick` is 1. Outside triangle mode it counts up and wraps from 0xFFFF to 0x0000.
- R3: In compare mode (`mode_sel` 2'b00, and 2'b11 behaves the same), a tick cycle on which the counter equals GR copies BR into GR.
- R4: In capture mode (`mode_sel` 2'b01), a capture event loads the counter into GR and, in the same cycle, moves GR's previous value into BR.
- R5: The capture pin passes through two synchronizing flops. `edge_sel` 2'b01 captures on rising edges, 2'b10 on falling edges, 2'b11 on both, and 2'b00 on none.
- R6: In triangle mode (`mode_sel` 2'b10), the counter climbs to the period, then falls to 0, then climbs again. On the tick at the period it turns down to period-1, and on the tick at 0 it turns up to 1. GR is reloaded from BR only on those two turn ticks.
- R7: `pwm_out` is 1 exactly when the mode is triangle and the counter is at or above GR. In all other modes it is 0.
- R8: The register addresses are 0 for GR, 1 for BR, 2 for the period and 3 for the flag (read bit 0). A write to BR changes only BR. A write to GR takes effect on the next edge, except that a hardware load of GR in the same cycle wins.
- R9: `evt_flag` is set by a compare match, a capture or a triangle turn. It stays set until a write to address 3 with data bit 0 equal to 1, and a new event in the same cycle as the clear wins. A write with bit 0 equal to 0 leaves the flag as it is.
- R10: With `BUF_EN`=0, BR reads 0, no event moves anything into GR, and a capture still loads the counter into GR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one count per high cycle |
| cap_pin | input | 1 | Asynchronous capture input |
| mode_sel | input | 2 | 00/11 compare, 01 capture, 10 triangle PWM |
| edge_sel | input | 2 | Capture edge: bit 0 rising, bit 1 falling |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| evt_flag | output | 1 | Sticky event flag |
| pwm_out | output | 1 | Triangle PWM output |

## Verification
The bench captures twice in a row and reads back both GR and BR. A channel that copied the counter into BR, or lost the older value, would show the wrong pair. It also writes BR in the middle of a slope and a second time while a compare match is pending. GR must change only at the next turn or match, so a design that let the BR write through at once, or reloaded GR on every tick, would be caught mid-slope. A CPU write to GR is placed in the same cycle as a match to check that the hardware load wins. The bench also sweeps all four edge selections in both pin directions and runs the counter through a full wrap past 0xFFFF.

// File: rtl/buf_timer_pkg.sv
package buf_timer_pkg;
    typedef enum logic [1:0] {
        MODE_CMP = 2'b00,
        MODE_CAP = 2'b01,
        MODE_TRI = 2'b10,
        MODE_ALT = 2'b11
    } chan_mode_e;

    typedef enum logic [1:0] {
        REG_GR  = 2'd0,
        REG_BR  = 2'd1,
        REG_PER = 2'd2,
        REG_FLG = 2'd3
    } reg_sel_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_state_e;
endpackage

// File: rtl/cap_edge_detect.sv
module cap_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] edge_sel,
    output logic       cap_evt
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;
    logic             synced, prev;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN-2:0], pin};
    end

    assign synced = chain_q[SYNC_STAGES-1];
    assign prev   = chain_q[SYNC_STAGES];

    always_comb begin
        cap_evt = (edge_sel[0] && synced && !prev) ||
                  (edge_sel[1] && !synced && prev);
    end
endmodule

// File: rtl/tri_counter.sv
module tri_counter
    import buf_timer_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  chan_mode_e    mode,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] cnt,
    output logic          turn_evt
);
    localparam logic [CW-1:0] ONE = CW'(1);

    dir_state_e    dir_q, dir_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          peak_turn, floor_turn;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= DIR_UP;
            cnt_q <= '0;
        end else begin
            dir_q <= dir_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        dir_d      = dir_q;
        cnt_d      = cnt_q;
        peak_turn  = 1'b0;
        floor_turn = 1'b0;
        if (mode != MODE_TRI) begin
            dir_d = DIR_UP;
            if (tick) cnt_d = cnt_q + ONE;
        end else begin
            unique case (dir_q)
                DIR_UP: begin
                    if (tick) begin
                        if (cnt_q == period) begin
                            peak_turn = 1'b1;
                            dir_d     = DIR_DOWN;
                            cnt_d     = (period == '0) ? '0 : cnt_q - ONE;
                        end else begin
                            cnt_d = cnt_q + ONE;
                        end
                    end
                end
                DIR_DOWN: begin
                    if (tick) begin
                        if (cnt_q == '0) begin
                            floor_turn = 1'b1;
                            dir_d      = DIR_UP;
                            cnt_d      = (period == '0) ? '0 : ONE;
                        end else begin
                            cnt_d = cnt_q - ONE;
                        end
                    end
                end
            endcase
        end
    end

    assign cnt      = cnt_q;
    assign turn_evt = peak_turn || floor_turn;
endmodule

// File: rtl/buf_regs.sv
module buf_regs
    import buf_timer_pkg::*;
#(
    parameter int CW     = 16,
    parameter bit BUF_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  chan_mode_e    mode,
    input  logic          tick,
    input  logic [CW-1:0] cnt,
    input  logic          cap_evt,
    input  logic          turn_evt,
    input  logic          wr_gr,
    input  logic          wr_br,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] gr,
    output logic [CW-1:0] br,
    output logic          hw_evt
);
    logic [CW-1:0] gr_q;
    logic          cmp_hit, cap_load, tri_load;

    always_comb begin
        cmp_hit  = (mode == MODE_CMP || mode == MODE_ALT) && tick && (cnt == gr_q);
        cap_load = (mode == MODE_CAP) && cap_evt;
        tri_load = (mode == MODE_TRI) && turn_evt;
        hw_evt   = cmp_hit || cap_load || tri_load;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                  gr_q <= '0;
        else if (cap_load)                           gr_q <= cnt;
        else if ((cmp_hit || tri_load) && BUF_EN)    gr_q <= br;
        else if (wr_gr)                              gr_q <= wr_data;
    end

    generate
        if (BUF_EN) begin : g_buf
            logic [CW-1:0] br_q;
            always_ff @(posedge clk) begin
                if (!rst_n)        br_q <= '0;
                else if (cap_load) br_q <= gr_q;
                else if (wr_br)    br_q <= wr_data;
            end
            assign br = br_q;
        end else begin : g_nobuf
            assign br = '0;
        end
    endgenerate

    assign gr = gr_q;
endmodule

// File: rtl/buf_timer_chan.sv
module buf_timer_chan
    import buf_timer_pkg::*;
#(
    parameter int CW          = 16,
    parameter bit BUF_EN      = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cap_pin,
    input  logic [1:0]    mode_sel,
    input  logic [1:0]    edge_sel,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [1:0]    rd_addr,
    output logic [CW-1:0] rd_data,
    output logic          evt_flag,
    output logic          pwm_out
);
    chan_mode_e    mode;
    reg_sel_e      wsel, rsel;
    logic [CW-1:0] cnt_q, gr_q, br_q, per_q;
    logic          cap_evt, turn_evt, hw_evt, flag_q, flag_clr;

    assign mode = chan_mode_e'(mode_sel);
    assign wsel = reg_sel_e'(wr_addr);
    assign rsel = reg_sel_e'(rd_addr);

    cap_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin(cap_pin),
        .edge_sel(edge_sel), .cap_evt(cap_evt)
    );

    tri_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
        .period(per_q), .cnt(cnt_q), .turn_evt(turn_evt)
    );

    buf_regs #(.CW(CW), .BUF_EN(BUF_EN)) u_regs (
        .clk(clk), .rst_n(rst_n), .mode(mode), .tick(tick), .cnt(cnt_q),
        .cap_evt(cap_evt), .turn_evt(turn_evt),
        .wr_gr(wr_en && wsel == REG_GR), .wr_br(wr_en && wsel == REG_BR),
        .wr_data(wr_data), .gr(gr_q), .br(br_q), .hw_evt(hw_evt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                          per_q <= '0;
        else if (wr_en && wsel == REG_PER)   per_q <= wr_data;
    end

    assign flag_clr = wr_en && (wsel == REG_FLG) && wr_data[0];

    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (hw_evt)   flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    always_comb begin
        unique case (rsel)
            REG_GR:  rd_data = gr_q;
            REG_BR:  rd_data = br_q;
            REG_PER: rd_data = per_q;
            REG_FLG: rd_data = {{(CW-1){1'b0}}, flag_q};
        endcase
    end

    assign evt_flag = flag_q;
    assign pwm_out  = (mode == MODE_TRI) && (cnt_q >= gr_q);
endmodule

// File: rtl/buf_timer_chan_chk.sv
module buf_timer_chan_chk #(
    parameter int CW     = 16,
    parameter bit BUF_EN = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic [1:0]    mode_sel,
    input logic          wr_en,
    input logic [1:0]    wr_addr,
    input logic [CW-1:0] wr_data,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] gr,
    input logic [CW-1:0] br,
    input logic          cap_evt,
    input logic          turn_evt,
    input logic          evt_flag
);
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    a_r3_compare_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (BUF_EN && mode_sel != 2'b01 && mode_sel != 2'b10 && tick && cnt == gr)
        |=> gr == $past(br));

    a_r4_capture_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01 && cap_evt)
        |=> (gr == $past(cnt)) && (!BUF_EN || br == $past(gr)));

    a_r6_no_midslope_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b10 && !turn_evt && !(wr_en && wr_addr == 2'd0))
        |=> $stable(gr));

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flag && !(wr_en && wr_addr == 2'd3 && wr_data[0])) |=> evt_flag);

    a_r10_br_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !BUF_EN |-> br == '0);
endmodule

bind buf_timer_chan buf_timer_chan_chk #(.CW(CW), .BUF_EN(BUF_EN)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_sel(mode_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt(cnt_q), .gr(gr_q), .br(br_q), .cap_evt(cap_evt),
    .turn_evt(turn_evt), .evt_flag(evt_flag)
);

// File: tb/tb_buf_timer_chan.sv
`timescale 1ns/1ps
module tb_buf_timer_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        cap_pin = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic [1:0]  edge_sel = 2'b00;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data, nb_rd_data;
    logic        evt_flag, pwm_out, nb_flag, nb_pwm;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    buf_timer_chan dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cap_pin(cap_pin),
        .mode_sel(mode_sel), .edge_sel(edge_sel), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .evt_flag(evt_flag), .pwm_out(pwm_out)
    );

    buf_timer_chan #(.BUF_EN(1'b0)) dut_nb (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cap_pin(cap_pin),
        .mode_sel(mode_sel), .edge_sel(edge_sel), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(nb_rd_data), .evt_flag(nb_flag), .pwm_out(nb_pwm)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v, output logic [15:0] vn);
        rd_addr = a;
        #0.2;
        v  = rd_data;
        vn = nb_rd_data;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        step(n);
        tick = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; cap_pin = 1'b0;
        step(4);
        rst_n = 1'b1;
        step(1);
    endtask

    initial begin : watchdog
        #(200000 * 5.0);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] v, vn;
        int m_cnt, m_gr, m_br, m_per;
        bit m_up;

        // R1: reset state
        do_reset();
        rd(2'd0, v, vn); chk(v == 0, "R1 GR", v, 0);
        rd(2'd1, v, vn); chk(v == 0, "R1 BR", v, 0);
        rd(2'd2, v, vn); chk(v == 0, "R1 period", v, 0);
        chk(evt_flag == 0 && pwm_out == 0, "R1 flag/pwm", {evt_flag, pwm_out}, 0);

        // R4 / R10: two-deep capture history, both edges
        mode_sel = 2'b01; edge_sel = 2'b11;
        ticks(5);
        cap_pin = 1'b1; step(4);
        rd(2'd0, v, vn); chk(v == 5, "R4 first capture GR", v, 5);
        rd(2'd1, v, vn); chk(v == 0, "R4 first capture BR", v, 0);
        chk(evt_flag == 1, "R9 set by capture", evt_flag, 1);
        ticks(7);
        cap_pin = 1'b0; step(4);
        rd(2'd0, v, vn); chk(v == 12, "R4 second capture GR", v, 12);
        chk(vn == 12, "R10 capture without buffer GR", vn, 12);
        rd(2'd1, v, vn); chk(v == 5, "R4 history BR", v, 5);
        chk(vn == 0, "R10 BR reads zero", vn, 0);
        ticks(3);
        cap_pin = 1'b1; step(4);
        rd(2'd0, v, vn); chk(v == 15, "R4 third capture GR", v, 15);
        rd(2'd1, v, vn); chk(v == 12, "R4 third capture BR", v, 12);

        // R5: edge select sweep
        for (int es = 0; es < 4; es++) begin
            int exp_gr;
            do_reset();
            mode_sel = 2'b01; edge_sel = es[1:0];
            ticks(3);
            cap_pin = 1'b1; step(4);
            exp_gr = es[0] ? 3 : 0;
            rd(2'd0, v, vn); chk(v == exp_gr, "R5 rising sweep", v, exp_gr);
            ticks(2);
            cap_pin = 1'b0; step(4);
            if (es[1]) exp_gr = 5;
            rd(2'd0, v, vn); chk(v == exp_gr, "R5 falling sweep", v, exp_gr);
            chk(evt_flag == (es != 0), "R5 flag per edge", evt_flag, es != 0);
        end

        // R2: counter wraps past 0xFFFF
        do_reset();
        mode_sel = 2'b01; edge_sel = 2'b01;
        ticks(65537);
        cap_pin = 1'b1; step(4);
        rd(2'd0, v, vn); chk(v == 1, "R2 wrap", v, 1);

        // R3 / R8 / R9: compare reload and deferred BR
        do_reset();
        mode_sel = 2'b00;
        wr(2'd0, 16'd3);
        wr(2'd1, 16'd7);
        rd(2'd0, v, vn); chk(v == 3, "R8 BR write deferred", v, 3);
        ticks(3);
        rd(2'd0, v, vn); chk(v == 3, "R3 no early reload", v, 3);
        chk(evt_flag == 0, "R9 no flag before match", evt_flag, 0);
        ticks(1);
        rd(2'd0, v, vn); chk(v == 7, "R3 reload on match", v, 7);
        chk(vn == 3, "R10 no reload without buffer", vn, 3);
        chk(evt_flag == 1, "R9 set by match", evt_flag, 1);
        chk(pwm_out == 0, "R7 low outside triangle", pwm_out, 0);
        wr(2'd3, 16'd0);
        chk(evt_flag == 1, "R9 write 0 keeps flag", evt_flag, 1);
        wr(2'd3, 16'd1);
        chk(evt_flag == 0, "R9 clear by write 1", evt_flag, 0);
        wr(2'd1, 16'd9);
        rd(2'd0, v, vn); chk(v == 7, "R8 BR write deferred again", v, 7);
        ticks(3);
        tick = 1'b1;
        wr(2'd0, 16'd100);
        tick = 1'b0;
        rd(2'd0, v, vn); chk(v == 9, "R8 hardware load beats CPU write", v, 9);
        chk(vn == 100, "R10 CPU write lands without buffer", vn, 100);
        wr(2'd0, 16'd20);
        rd(2'd0, v, vn); chk(v == 20, "R8 GR write immediate", v, 20);

        // R6 / R7: triangle PWM against a bench model
        do_reset();
        mode_sel = 2'b10;
        wr(2'd2, 16'd5);
        wr(2'd0, 16'd2);
        wr(2'd1, 16'd4);
        m_cnt = 0; m_up = 1; m_gr = 2; m_br = 4; m_per = 5;
        for (int i = 0; i < 40; i++) begin
            bit turn, wgr, wbr;
            wgr = (i == 27); wbr = (i == 13);
            tick = 1'b1;
            wr_en = wgr || wbr;
            wr_addr = wgr ? 2'd0 : 2'd1;
            wr_data = wgr ? 16'd3 : 16'd1;
            turn = 0;
            if (m_up) begin
                if (m_cnt == m_per) begin turn = 1; m_up = 0; m_cnt = m_per - 1; end
                else m_cnt++;
            end else begin
                if (m_cnt == 0) begin turn = 1; m_up = 1; m_cnt = 1; end
                else m_cnt--;
            end
            if (turn) m_gr = m_br;
            else if (wgr) m_gr = 3;
            if (wbr) m_br = 1;
            step(1);
            wr_en = 1'b0;
            rd(2'd0, v, vn);
            chk(v == m_gr, "R6 GR only reloads at turns", v, m_gr);
            chk(pwm_out == (m_cnt >= m_gr), "R7 pwm level", pwm_out, m_cnt >= m_gr);
        end
        tick = 1'b0;
        rd(2'd0, v, vn); chk(vn == 3, "R10 no turn reload without buffer", vn, 3);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule